// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a phase-locked loop through a safe change of its divider settings. The loop is controlled by two 32-bit registers: a divider register (address 0) and a control register (address 1). A caller presents the feedback, reference and output divider values as true values and pulses `start`. The sequencer then emits four single-cycle register writes in a fixed order. First the loop is held in reset with its output bypassed. Next the new dividers are loaded. Reset is then released with fast locking enabled. Finally bypass and fast locking are dropped together.

The two waits are counted in reference clock cycles. The settling time after the divider write is a fixed count derived from the reference frequency parameter. The lock time grows with the reference divider. No lock detector is used: the loop is taken to be locked once the timed wait has elapsed. `busy` covers the whole sequence, and `done` marks the cycle of the final write.

Top module: `pll_reprog_seq`

## Requirements
- R1: The address-0 write carries (F-1) in bits 16:4 and (OD-1) in bits 2:0. Bits 19:17 and bit 3 are zero.
- R2: Bits 31:20 of the address-0 write equal the encoded feedback value (F-1) shifted right by one bit.
- R3: The first write of a sequence goes to address 1 with bit 28 (reset), bit 26 (saturation enable) and bit 25 (bypass) set, bits 27 and 24 clear, and (R-1) in bits 5:0.
- R4: The address-0 write comes in the cycle immediately after the first address-1 write and never ahead of it.
- R5: The reset-release write comes exactly SETTLE_CYC+1 cycles after the address-0 write, where SETTLE_CYC = REF_MHZ*5 (5 us of reference clock).
- R6: The reset-release write goes to address 1 with bit 28 clear and bits 27 (fast-lock enable), 26 and 25 set, keeping (R-1) in bits 5:0.
- R7: The final write comes exactly LOCK_PERIODS*R+1 cycles after the reset-release write (LOCK_PERIODS = 500).
- R8: The final write goes to address 1 with bits 28, 27, 25 and 24 clear and bit 26 set, keeping (R-1) in bits 5:0.
- R9: A sequence makes exactly four writes. `busy` is high from the first write through the final write and low afterwards. `done` is high only in the cycle of the final write.
- R10: A `start` pulse raised while `busy` is high has no effect: the write count and the timing of the running sequence are unchanged, and no further writes follow.
- R11: While reset is held, and while idle, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reprogramming sequence |
| f_val | input | 14 | Feedback divider, true value 1..8192 |
| r_val | input | 7 | Reference divider, true value 1..64 |
| od_val | input | 4 | Output divider, true value 1..8 |
| wr_en | output | 1 | Register write strobe, one cycle |
| wr_addr | output | 1 | Register select: 0 divider, 1 control |
| wr_data | output | 32 | Register image being written |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final write of the sequence |

## Verification
The assertions assume that each divider input holds a true value within its legal range, so that subtracting one never wraps. They also assume that the inputs stay stable while `start` is sampled. The stimulus only drives values from 1 up to each field's maximum, and it changes the dividers only at a falling edge before a `start` pulse. The bench covers the smallest and largest dividers, an odd feedback value to exercise the rounding of the bandwidth field, and a `start` pulse raised during the lock wait.

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int REF_MHZ      = 4,
  parameter int SETTLE_US    = 5,
  parameter int LOCK_PERIODS = 500,
  parameter int F_W          = 13,
  parameter int R_W          = 6,
  parameter int OD_W         = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [F_W:0]   f_val,
  input  logic [R_W:0]   r_val,
  input  logic [OD_W:0]  od_val,
  output logic           wr_en,
  output logic           wr_addr,
  output logic [31:0]    wr_data,
  output logic           busy,
  output logic           done
);
  localparam int SETTLE_CYC = REF_MHZ * SETTLE_US;
  localparam int LOCK_MAX   = LOCK_PERIODS * (1 << R_W);
  localparam int CNT_W      = $clog2(LOCK_MAX + SETTLE_CYC + 1);
  localparam int F_LSB      = 4;
  localparam int BW_LSB     = 20;
  localparam int B_RST      = 28;
  localparam int B_FAST     = 27;
  localparam int B_SAT      = 26;
  localparam int B_BYP      = 25;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_DIV, S_SETTLE, S_REL, S_LOCK, S_FIN
  } state_t;

  state_t           st;
  logic [F_W-1:0]   f_enc;
  logic [R_W-1:0]   r_enc;
  logic [OD_W-1:0]  od_enc;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lock_len;
  logic [31:0]      ctl0_img;
  logic [31:0]      ctl1_base;

  assign lock_len  = CNT_W'(LOCK_PERIODS) * (CNT_W'(r_enc) + CNT_W'(1));
  assign ctl0_img  = (32'(f_enc >> 1) << BW_LSB) | (32'(f_enc) << F_LSB) | 32'(od_enc);
  assign ctl1_base = 32'(r_enc) | (32'd1 << B_SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      f_enc  <= '0;
      r_enc  <= '0;
      od_enc <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          f_enc  <= F_W'(f_val - 1'b1);
          r_enc  <= R_W'(r_val - 1'b1);
          od_enc <= OD_W'(od_val - 1'b1);
          st     <= S_HOLD;
        end
        S_HOLD: st <= S_DIV;
        S_DIV: begin
          cnt <= CNT_W'(SETTLE_CYC - 1);
          st  <= S_SETTLE;
        end
        S_SETTLE: if (cnt == '0) st <= S_REL; else cnt <= cnt - 1'b1;
        S_REL: begin
          cnt <= lock_len - 1'b1;
          st  <= S_LOCK;
        end
        S_LOCK: if (cnt == '0) st <= S_FIN; else cnt <= cnt - 1'b1;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = 1'b1;
    wr_data = '0;
    case (st)
      S_HOLD: begin
        wr_en   = 1'b1;
        wr_data = ctl1_base | (32'd1 << B_RST) | (32'd1 << B_BYP);
      end
      S_DIV: begin
        wr_en   = 1'b1;
        wr_addr = 1'b0;
        wr_data = ctl0_img;
      end
      S_REL: begin
        wr_en   = 1'b1;
        wr_data = ctl1_base | (32'd1 << B_FAST) | (32'd1 << B_BYP);
      end
      S_FIN: begin
        wr_en   = 1'b1;
        wr_data = ctl1_base;
      end
      default: ;
    endcase
  end

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
  parameter int SETTLE_CYC = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wr_en,
  input logic        wr_addr,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done
);
  logic [31:0] since_div;

  always_ff @(posedge clk) begin
    if (!rst_n) since_div <= 32'hFFFF_FFFF;
    else if (wr_en && !wr_addr) since_div <= '0;
    else if (since_div != 32'hFFFF_FFFF) since_div <= since_div + 1'b1;
  end

  AST_DIV_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |-> $past(wr_en && wr_addr && wr_data[28])); // R4
  AST_BW_FROM_F: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |-> (wr_data[31:20] == wr_data[16:5])); // R2
  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && wr_data[27]) |-> (since_div >= SETTLE_CYC)); // R5
  AST_RELEASE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && wr_data[27]) |-> (!wr_data[28] && wr_data[26] && wr_data[25])); // R6
  AST_FINAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_en && wr_addr && wr_data[28:24] == 5'b00100)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_en && !done)); // R11
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .done(done)
);

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
  localparam int REF_MHZ = 4;
  localparam int SETTLE  = REF_MHZ * 5;
  localparam int LOCKP   = 500;
  localparam int NV      = 5;
  localparam int VF [NV] = '{1, 100, 8192, 37, 2049};
  localparam int VR [NV] = '{1, 2, 64, 5, 3};
  localparam int VO [NV] = '{1, 4, 8, 2, 7};
  localparam bit VX [NV] = '{0, 0, 0, 0, 1};

  logic clk = 0, rst_n = 0, start = 0;
  logic [13:0] f_val = 1;
  logic [6:0]  r_val = 1;
  logic [3:0]  od_val = 1;
  logic wr_en, wr_addr, busy, done;
  logic [31:0] wr_data;
  int checks = 0, fails = 0, cyc = 0;

  pll_reprog_seq #(.REF_MHZ(REF_MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .f_val(f_val), .r_val(r_val),
    .od_val(od_val), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done));

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic run_seq(int f, int r, int od, bit extra);
    int n, nw, done_c, busy_bad, late;
    int wa[4], wd[4], wc[4];
    int c0, c1a, c1b, c1c;
    for (int i = 0; i < 4; i++) begin wa[i] = -1; wd[i] = -1; wc[i] = -1; end
    f_val = 14'(f); r_val = 7'(r); od_val = 4'(od);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 1; nw = 0; done_c = -1; busy_bad = 0;
    while (done_c < 0 && n < 40000) begin
      start = (extra && n == 30);
      if (!busy) busy_bad++;
      if (wr_en) begin
        if (nw < 4) begin wa[nw] = int'(wr_addr); wd[nw] = int'(wr_data); wc[nw] = n; end
        nw++;
      end
      if (done) done_c = n;
      @(negedge clk);
      n++;
    end
    start = 0;
    c1a = (1 << 28) | (1 << 26) | (1 << 25) | (r - 1);
    c0  = (((f - 1) >> 1) << 20) | ((f - 1) << 4) | (od - 1);
    c1b = (1 << 27) | (1 << 26) | (1 << 25) | (r - 1);
    c1c = (1 << 26) | (r - 1);
    chk(nw == 4, extra ? "R10 write count" : "R9 write count", nw, 4);
    chk(wa[0] == 1 && wd[0] == c1a, "R3 hold write", wd[0], c1a);
    chk(wa[1] == 0 && wd[1] == c0, "R1 divider write", wd[1], c0);
    chk(wd[1][31:20] == 12'((f - 1) >> 1), "R2 bandwidth field", wd[1][31:20], (f - 1) >> 1);
    chk(wc[1] - wc[0] == 1, "R4 divider follows hold", wc[1] - wc[0], 1);
    chk(wc[2] - wc[1] == SETTLE + 1, "R5 settle gap", wc[2] - wc[1], SETTLE + 1);
    chk(wa[2] == 1 && wd[2] == c1b, "R6 release write", wd[2], c1b);
    chk(wc[3] - wc[2] == LOCKP * r + 1, extra ? "R10 lock gap" : "R7 lock gap",
        wc[3] - wc[2], LOCKP * r + 1);
    chk(wa[3] == 1 && wd[3] == c1c, "R8 final write", wd[3], c1c);
    chk(done_c == wc[3] && busy_bad == 0, "R9 done and busy", done_c, wc[3]);
    chk(!busy && !done && !wr_en, "R9 idle after done", {busy, done, wr_en}, 0);
    late = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (wr_en || busy) late++;
    end
    chk(late == 0, "R10 no further writes", late, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en, "R11 in reset", {busy, done, wr_en}, 0);
    start = 1;
    @(negedge clk);
    chk(!busy && !wr_en, "R11 start during reset", {busy, wr_en}, 0);
    start = 0;
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !wr_en, "R11 idle after reset", {busy, done, wr_en}, 0);
    for (int v = 0; v < NV; v++) run_seq(VF[v], VR[v], VO[v], VX[v]);
    summary();
  end
endmodule